// File: doc/BRIEF.md
# Multi-Sensor Thermal Threshold Monitor

The block watches several digital temperature sense points spread over a multi-core die. A free-running scan window of fixed length gathers every valid reading; at the end of each window it publishes the hottest reading of each core and the hottest reading of the whole die. Software programs a lower and an upper threshold. The block compares a chosen reading (the die maximum or one core's maximum) with both thresholds and raises a one-cycle interrupt only when the reading crosses a threshold between two consecutive windows. Each interrupt goes to the cores that the routing mask selects.

A separate hot level drives a self-throttle request. The request steps up one level for each window spent above the hot level and steps down one level for each window spent at or below it. When the die stays hot at the top throttle level for a programmed number of consecutive windows, the block pulses an out-of-spec interrupt and sets a sticky warning flag that only a software write clears. An external hot input also forces the throttle request.

Top module: `thermal_monitor`

## Requirements
- R1: Each core's reading is the largest value, over all of that core's sense points, seen with its valid strobe high during a window of SCAN_CYCLES clocks. The reading is registered only on the last clock of the window. A window with no valid strobe gives 0. The first window ends on the SCAN_CYCLES-th rising edge after reset is released.
- R2: The die reading is the largest of the core readings. It updates on the same edge as they do.
- R3: Config register (address 3): bit 4 set selects the die reading for threshold comparison. When bit 4 is clear, bits [5 +: log2(NUM_CORES)] give the index of the core whose reading is compared.
- R4: An upward interrupt fires when the previous selected value was at or below the upper threshold (address 1) and the new value is above it.
- R5: A downward interrupt fires when the previous selected value was at or above the lower threshold (address 0) and the new value is below it. The previous value is 0 after reset.
- R6: A selected value that stays beyond a threshold in later windows raises no further interrupt.
- R7: Interrupts are one-cycle pulses, one bit per core. They are asserted on the edge that ends the window, on the cores whose bit is set in config bits [NUM_CORES-1:0].
- R8: At each window end, the throttle level rises by one (saturating at MAX_LVL) if the die reading is above the hot threshold (address 2). Otherwise it falls by one, saturating at 0.
- R9: The throttle request is high whenever the level is non-zero or the external hot input is high.
- R10: A window that ends with the die reading above the hot threshold while the level was already MAX_LVL counts as one consecutive hot window. Any other window resets the count. The out-of-spec pulse fires once, on the window whose count reaches the limit (address 4). A limit of 0 never fires.
- R11: The out-of-spec flag sets with the pulse. It stays set until a write of 1 in bit 0 to address 5. When the set and the clear fall on the same edge, the set wins.
- R12: Reset values are lower 0, upper 255, hot 255, limit 0, and config with die source and every core routed. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_val | input | NUM_CORES*PTS_PER_CORE*8 | Sense point readings, point p at bits [p*8 +: 8], core c owns points c*PTS_PER_CORE onward |
| sens_vld | input | NUM_CORES*PTS_PER_CORE | Valid strobe per sense point |
| ext_hot | input | 1 | External hot indication forcing throttle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| core_temp | output | NUM_CORES*8 | Per-core maximum reading |
| die_temp | output | 8 | Die-wide maximum reading |
| irq_up | output | NUM_CORES | Upward crossing interrupt per core |
| irq_dn | output | NUM_CORES | Downward crossing interrupt per core |
| throttle_req | output | 1 | Throttle request |
| throttle_lvl | output | $clog2(MAX_LVL+1) | Current throttle level |
| oos_irq | output | 1 | Out-of-spec pulse |
| oos_flag | output | 1 | Sticky out-of-spec flag |

## Verification
Random readings with random strobes, which change every cycle, exercise the per-window maximum and show whether invalid points or readings that straddle a window boundary leak into a result. A stepped profile of held temperatures walks the reading through each threshold in both directions. It tells a true crossing apart from a level that stays beyond a threshold, and a change of source or routing mask shows which core a pulse reaches. A long hot plateau, a clear, a cooldown and a second plateau separate throttle stepping from the consecutive-window count and the sticky behaviour of the flag.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int TW = 8;
  typedef logic [TW-1:0] temp_t;

  typedef enum logic [2:0] {
    RA_LOWER = 3'd0,
    RA_UPPER = 3'd1,
    RA_HOT   = 3'd2,
    RA_CFG   = 3'd3,
    RA_LIMIT = 3'd4,
    RA_CLEAR = 3'd5
  } reg_addr_e;

  function automatic temp_t tmax(temp_t a, temp_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tm_scan.sv
module tm_scan
  import tm_pkg::*;
#(
  parameter int NC  = 2,
  parameter int PPC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_end,
  input  logic [NC*PPC*TW-1:0]   sens_val,
  input  logic [NC*PPC-1:0]      sens_vld,
  output logic [NC*TW-1:0]       core_q,
  output logic [NC*TW-1:0]       core_nx,
  output temp_t                  die_q,
  output temp_t                  die_nx
);
  genvar c;
  generate
    for (c = 0; c < NC; c++) begin : g_core
      temp_t acc_q, acc_d, cur_q, cur_d, upd;

      always_comb begin
        upd = acc_q;
        for (int k = 0; k < PPC; k++) begin
          if (sens_vld[c*PPC+k]) upd = tmax(upd, sens_val[(c*PPC+k)*TW +: TW]);
        end
        acc_d = scan_end ? '0 : upd;
        cur_d = scan_end ? upd : cur_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q <= '0;
          cur_q <= '0;
        end else begin
          acc_q <= acc_d;
          cur_q <= cur_d;
        end
      end

      assign core_nx[c*TW +: TW] = upd;
      assign core_q[c*TW +: TW]  = cur_q;
    end
  endgenerate

  always_comb begin
    die_nx = '0;
    for (int i = 0; i < NC; i++) die_nx = tmax(die_nx, core_nx[i*TW +: TW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        die_q <= '0;
    else if (scan_end) die_q <= die_nx;
  end
endmodule

// File: rtl/tm_thresh.sv
module tm_thresh
  import tm_pkg::*;
#(
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_end,
  input  temp_t         sel_nx,
  input  temp_t         lo_thr,
  input  temp_t         hi_thr,
  input  logic [NC-1:0] route,
  output logic [NC-1:0] irq_up,
  output logic [NC-1:0] irq_dn
);
  temp_t         prev_q, prev_d;
  logic [NC-1:0] up_d, dn_d;

  always_comb begin
    prev_d = scan_end ? sel_nx : prev_q;
    up_d   = (scan_end && prev_q <= hi_thr && sel_nx > hi_thr) ? route : '0;
    dn_d   = (scan_end && prev_q >= lo_thr && sel_nx < lo_thr) ? route : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irq_up <= '0;
      irq_dn <= '0;
    end else begin
      prev_q <= prev_d;
      irq_up <= up_d;
      irq_dn <= dn_d;
    end
  end
endmodule

// File: rtl/tm_escalate.sv
module tm_escalate
  import tm_pkg::*;
#(
  parameter int MAX_LVL = 3,
  localparam int LW     = $clog2(MAX_LVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_end,
  input  temp_t         die_nx,
  input  temp_t         hot_thr,
  input  logic [7:0]    limit,
  input  logic          clr,
  output logic [LW-1:0] lvl_q,
  output logic          oos_irq,
  output logic          oos_flag
);
  logic [LW-1:0] lvl_d;
  logic [7:0]    cnt_q, cnt_d;
  logic          fire, flag_d;
  logic          hot, at_max;

  always_comb begin
    hot    = die_nx > hot_thr;
    at_max = lvl_q == LW'(MAX_LVL);
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    if (scan_end) begin
      if (hot && at_max) begin
        fire  = ({1'b0, cnt_q} + 9'd1) == {1'b0, limit};
        cnt_d = (cnt_q == 8'hFF) ? cnt_q : cnt_q + 8'd1;
      end else begin
        cnt_d = '0;
      end
      if (hot)                lvl_d = at_max ? lvl_q : lvl_q + 1'b1;
      else if (lvl_q != '0)   lvl_d = lvl_q - 1'b1;
    end
    flag_d = fire ? 1'b1 : (clr ? 1'b0 : oos_flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      cnt_q    <= '0;
      oos_irq  <= 1'b0;
      oos_flag <= 1'b0;
    end else begin
      lvl_q    <= lvl_d;
      cnt_q    <= cnt_d;
      oos_irq  <= fire;
      oos_flag <= flag_d;
    end
  end
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor
  import tm_pkg::*;
#(
  parameter int NUM_CORES    = 2,   // power of two, at most 4
  parameter int PTS_PER_CORE = 3,
  parameter int SCAN_CYCLES  = 16,
  parameter int MAX_LVL      = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_CORES*PTS_PER_CORE*8-1:0]  sens_val,
  input  logic [NUM_CORES*PTS_PER_CORE-1:0]    sens_vld,
  input  logic                                 ext_hot,
  input  logic                                 wr_en,
  input  logic [2:0]                           wr_addr,
  input  logic [7:0]                           wr_data,
  output logic [NUM_CORES*8-1:0]               core_temp,
  output logic [7:0]                           die_temp,
  output logic [NUM_CORES-1:0]                 irq_up,
  output logic [NUM_CORES-1:0]                 irq_dn,
  output logic                                 throttle_req,
  output logic [$clog2(MAX_LVL+1)-1:0]         throttle_lvl,
  output logic                                 oos_irq,
  output logic                                 oos_flag
);
  localparam int SCW = $clog2(SCAN_CYCLES);
  localparam int CW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [SCW-1:0]       scnt_q, scnt_d;
  logic                 scan_end;
  temp_t                lo_q, lo_d, hi_q, hi_d, hot_q, hot_d, lim_q, lim_d;
  logic [NUM_CORES-1:0] route_q, route_d;
  logic                 dsel_q, dsel_d;
  logic [CW-1:0]        idx_q, idx_d;
  logic                 clr;
  logic [NUM_CORES*TW-1:0] core_nx;
  temp_t                die_nx, sel_nx;

  // scan window counter
  always_comb begin
    scan_end = scnt_q == SCW'(SCAN_CYCLES - 1);
    scnt_d   = scan_end ? '0 : scnt_q + 1'b1;
  end

  // register file next state
  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    hot_d   = hot_q;
    lim_d   = lim_q;
    route_d = route_q;
    dsel_d  = dsel_q;
    idx_d   = idx_q;
    if (wr_en) begin
      case (wr_addr)
        RA_LOWER: lo_d  = wr_data;
        RA_UPPER: hi_d  = wr_data;
        RA_HOT:   hot_d = wr_data;
        RA_LIMIT: lim_d = wr_data;
        RA_CFG: begin
          route_d = wr_data[NUM_CORES-1:0];
          dsel_d  = wr_data[4];
          idx_d   = wr_data[5 +: CW];
        end
        default: ;
      endcase
    end
    clr = wr_en && (wr_addr == RA_CLEAR) && wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '1;
      hot_q   <= '1;
      lim_q   <= '0;
      route_q <= '1;
      dsel_q  <= 1'b1;
      idx_q   <= '0;
    end else begin
      scnt_q  <= scnt_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      hot_q   <= hot_d;
      lim_q   <= lim_d;
      route_q <= route_d;
      dsel_q  <= dsel_d;
      idx_q   <= idx_d;
    end
  end

  tm_scan #(.NC(NUM_CORES), .PPC(PTS_PER_CORE)) u_scan (
    .clk(clk), .rst_n(rst_n), .scan_end(scan_end),
    .sens_val(sens_val), .sens_vld(sens_vld),
    .core_q(core_temp), .core_nx(core_nx),
    .die_q(die_temp), .die_nx(die_nx)
  );

  assign sel_nx = dsel_q ? die_nx : core_nx[idx_q*TW +: TW];

  tm_thresh #(.NC(NUM_CORES)) u_thresh (
    .clk(clk), .rst_n(rst_n), .scan_end(scan_end), .sel_nx(sel_nx),
    .lo_thr(lo_q), .hi_thr(hi_q), .route(route_q),
    .irq_up(irq_up), .irq_dn(irq_dn)
  );

  tm_escalate #(.MAX_LVL(MAX_LVL)) u_esc (
    .clk(clk), .rst_n(rst_n), .scan_end(scan_end), .die_nx(die_nx),
    .hot_thr(hot_q), .limit(lim_q), .clr(clr),
    .lvl_q(throttle_lvl), .oos_irq(oos_irq), .oos_flag(oos_flag)
  );

  assign throttle_req = (throttle_lvl != '0) || ext_hot;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int NC      = 2,
  parameter int MAX_LVL = 3,
  localparam int LW     = $clog2(MAX_LVL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_end,
  input logic          ext_hot,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          wr_d0,
  input logic [NC*8-1:0] core_temp,
  input logic [NC-1:0] irq_up,
  input logic [NC-1:0] irq_dn,
  input logic          throttle_req,
  input logic [LW-1:0] throttle_lvl,
  input logic          oos_irq,
  input logic          oos_flag
);
  a_r1_update_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (core_temp != $past(core_temp)) |-> $past(scan_end));

  a_r7_pulse_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_up) || (|irq_dn)) |-> $past(scan_end));

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_lvl != $past(throttle_lvl)) |->
      ((throttle_lvl == $past(throttle_lvl) + 1'b1) || (throttle_lvl + 1'b1 == $past(throttle_lvl))));

  a_r9_ext_forces: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hot |-> throttle_req);

  a_r10_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    oos_irq |-> oos_flag);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oos_flag && !(wr_en && wr_addr == 3'd5 && wr_d0)) |=> oos_flag);
endmodule

bind thermal_monitor tm_checker #(.NC(NUM_CORES), .MAX_LVL(MAX_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_end(scan_end), .ext_hot(ext_hot),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_d0(wr_data[0]),
  .core_temp(core_temp), .irq_up(irq_up), .irq_dn(irq_dn),
  .throttle_req(throttle_req), .throttle_lvl(throttle_lvl),
  .oos_irq(oos_irq), .oos_flag(oos_flag)
);

// File: tb/sim_thermal_monitor.sv
`timescale 1ns/1ps
module sim_thermal_monitor;
  localparam int NC = 2, PPC = 3, SCAN = 16, MAXL = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC*PPC*8-1:0] sens_val;
  logic [NC*PPC-1:0]   sens_vld;
  logic ext_hot, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [NC*8-1:0] core_temp;
  logic [7:0] die_temp;
  logic [NC-1:0] irq_up, irq_dn;
  logic throttle_req, oos_irq, oos_flag;
  logic [1:0] throttle_lvl;

  always #10 clk = ~clk;

  thermal_monitor #(.NUM_CORES(NC), .PTS_PER_CORE(PPC), .SCAN_CYCLES(SCAN), .MAX_LVL(MAXL)) u0 (
    .clk(clk), .rst_n(rst_n), .sens_val(sens_val), .sens_vld(sens_vld),
    .ext_hot(ext_hot), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_temp(core_temp), .die_temp(die_temp), .irq_up(irq_up), .irq_dn(irq_dn),
    .throttle_req(throttle_req), .throttle_lvl(throttle_lvl),
    .oos_irq(oos_irq), .oos_flag(oos_flag)
  );

  int nvec = 0, nerr = 0;
  string phase = "R12 reset";

  // behavioural reference model
  int m_acc[NC], m_ct[NC];
  int m_die, m_prev, m_lvl, m_cnt, m_lo, m_hi, m_hot, m_cfg, m_lim, m_sc, m_up, m_dn;
  bit m_flag, m_oi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin m_acc[c] = 0; m_ct[c] = 0; end
      m_die = 0; m_prev = 0; m_lvl = 0; m_cnt = 0; m_lo = 0; m_hi = 255; m_hot = 255;
      m_cfg = 8'h13; m_lim = 0; m_sc = 0; m_up = 0; m_dn = 0; m_flag = 0; m_oi = 0;
    end else begin
      int nv[NC];
      int nd, s, idx, v;
      bit fin;
      m_up = 0; m_dn = 0; m_oi = 0;
      fin = (m_sc == SCAN - 1);
      for (int c = 0; c < NC; c++) begin
        v = m_acc[c];
        for (int k = 0; k < PPC; k++)
          if (sens_vld[c*PPC+k] && int'(sens_val[(c*PPC+k)*8 +: 8]) > v) v = int'(sens_val[(c*PPC+k)*8 +: 8]);
        nv[c] = v;
        m_acc[c] = fin ? 0 : v;
      end
      if (fin) begin
        nd = 0;
        for (int c = 0; c < NC; c++) begin m_ct[c] = nv[c]; if (nv[c] > nd) nd = nv[c]; end
        m_die = nd;
        idx = (m_cfg >> 5) & (NC - 1);
        s = ((m_cfg >> 4) & 1) ? nd : nv[idx];
        if (m_prev <= m_hi && s > m_hi) m_up = m_cfg & ((1 << NC) - 1);
        if (m_prev >= m_lo && s < m_lo) m_dn = m_cfg & ((1 << NC) - 1);
        m_prev = s;
        if (nd > m_hot) begin
          if (m_lvl == MAXL) begin
            if (m_cnt + 1 == m_lim) begin m_oi = 1; m_flag = 1; end
            if (m_cnt < 255) m_cnt++;
          end else m_cnt = 0;
          if (m_lvl < MAXL) m_lvl++;
        end else begin
          m_cnt = 0;
          if (m_lvl > 0) m_lvl--;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_lo = wr_data;
          3'd1: m_hi = wr_data;
          3'd2: m_hot = wr_data;
          3'd3: m_cfg = wr_data;
          3'd4: m_lim = wr_data;
          3'd5: if (wr_data[0] && !m_oi) m_flag = 0;
          default: ;
        endcase
      end
      m_sc = fin ? 0 : m_sc + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s [%s] at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
    end
  endtask

  // compare a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    for (int c = 0; c < NC; c++) chk("R1 core_temp", int'(core_temp[c*8 +: 8]), m_ct[c]);
    chk("R2 die_temp", int'(die_temp), m_die);
    chk("R4 irq_up", int'(irq_up), m_up);
    chk("R5 irq_dn", int'(irq_dn), m_dn);
    chk("R8 throttle_lvl", int'(throttle_lvl), m_lvl);
    chk("R9 throttle_req", int'(throttle_req), int'(m_lvl != 0 || ext_hot));
    chk("R10 oos_irq", int'(oos_irq), int'(m_oi));
    chk("R11 oos_flag", int'(oos_flag), int'(m_flag));
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_core(int c, int t, bit bad_pt);
    sens_val[(c*PPC)*8 +: 8]     = 8'(t);
    sens_val[(c*PPC+1)*8 +: 8]   = 8'(t > 5 ? t - 5 : 0);
    sens_val[(c*PPC+2)*8 +: 8]   = bad_pt ? 8'd250 : 8'(t > 9 ? t - 9 : 0);
    sens_vld[c*PPC +: PPC]       = bad_pt ? 3'b011 : 3'b111;
  endtask

  task automatic hold(int t0, int t1, int nscan);
    @(negedge clk);
    set_core(0, t0, 1'b0);
    set_core(1, t1, 1'b0);
    repeat (nscan * SCAN) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sens_val = '0; sens_vld = '0; ext_hot = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    phase = "R1 R2 random readings";
    for (int i = 0; i < 6 * SCAN; i++) begin
      @(negedge clk);
      sens_val = {$urandom, $urandom};
      sens_vld = 6'($urandom);
    end

    phase = "R1 invalid point ignored";
    @(negedge clk);
    set_core(0, 30, 1'b1);
    set_core(1, 25, 1'b1);
    repeat (2 * SCAN) @(negedge clk);
    phase = "R1 empty window reads zero";
    sens_vld = '0;
    repeat (2 * SCAN) @(negedge clk);

    phase = "R12 register writes and ignored addresses";
    wr(0, 40); wr(1, 70); wr(2, 90); wr(4, 3);
    wr(6, 8'h00); wr(7, 8'hFF);

    phase = "R4 R5 R6 crossings on die source";
    hold(60, 50, 2); hold(75, 50, 2); hold(80, 60, 2); hold(65, 60, 2);
    hold(35, 20, 2); hold(30, 10, 2); hold(50, 45, 2); hold(75, 70, 2);

    phase = "R3 R7 core1 source routed to core1";
    wr(3, 8'h22);
    hold(80, 50, 2); hold(80, 75, 2); hold(20, 30, 2);
    phase = "R3 R7 die source routed to core0";
    wr(3, 8'h11);
    hold(80, 30, 2); hold(20, 10, 2);

    phase = "R8 R10 R11 hot plateau";
    wr(3, 8'h13);
    hold(100, 95, 8);
    phase = "R11 clear while hot";
    wr(5, 1);
    hold(100, 95, 3);
    phase = "R8 cooldown";
    hold(50, 40, 5);
    phase = "R10 second plateau";
    hold(100, 100, 8);
    wr(5, 1);

    phase = "R9 external hot";
    hold(40, 40, 5);
    @(negedge clk); ext_hot = 1'b1;
    repeat (10) @(negedge clk);
    ext_hot = 1'b0;
    repeat (10) @(negedge clk);

    finish_run();
  end
endmodule